// File: doc/BRIEF.md
# Serial Port Register and FIFO Core

This block is the register-side core of an asynchronous serial port. It holds a transmit FIFO and a receive FIFO of 16 bytes each. Software reaches it through a 32-bit register bus with single-cycle reads and writes. An external transmit shifter drains the transmit FIFO through a byte port. An external receiver delivers characters, each with a parity-error and a framing-error strobe. The bit-level shifters and the baud-rate logic are outside this block.

Three interrupt lines are produced: transmit, receive and error. The transmit and receive lines come from pending bits that set when a FIFO crosses a software-chosen level. The error line follows a set of sticky error flags. The receiver has two states, RXS_OFF and RXS_ON. It leaves RXS_OFF for RXS_ON when the command register is written with the enable-set bit and without the enable-clear bit. It goes from RXS_ON back to RXS_OFF when the enable-clear bit is written. Error flags are cleared only through the write-only command register.

Register offsets: 0x00 error-enable control, 0x04 transmit FIFO control, 0x08 receive FIFO control, 0x0C FIFO status, 0x10 receiver status, 0x14 command (write-only), 0x18 interrupt enable, 0x1C interrupt clear (write-only), 0x20 transmit data (write), 0x24 receive data (read).

Top module: `uart_regcore`

## Requirements
- R1: The FIFO status word at 0x0C has the receive fill level in bits 5:0, the transmit fill level in bits 13:8 and the transmit free count (16 minus the fill level) in bits 29:24. All other bits read 0.
- R2: A character that arrives in RXS_ON with the receive FIFO enabled is stored. A read of 0x24 returns the oldest byte in bits 7:0 and pops it. A read of 0x24 on an empty FIFO returns 0 and changes no fill level.
- R3: A character that arrives in RXS_ON while the receive FIFO holds 16 entries sets the overrun flag (receiver status bit 19) and is dropped. The 16 stored bytes are kept in order.
- R4: The parity-error strobe sets receiver status bit 16 and the framing-error strobe sets bit 17. Each flag stays set until it is cleared by a command.
- R5: Command register bits: bit 0 moves the receiver to RXS_OFF (and wins when bit 1 is also set), bit 1 moves it to RXS_ON, bit 2 clears the parity flag, bit 3 clears the framing flag, bit 4 clears the transmit-overrun flag, and bit 5 clears the receive-overrun flag. A 0 bit has no effect. Receiver status bit 0 shows RXS_ON. Characters that arrive in RXS_OFF are dropped.
- R6: A write to 0x20 while the enabled transmit FIFO is full is dropped and sets the transmit-overrun flag (receiver status bit 18).
- R7: Control register bits 16, 17, 18 and 19 enable the parity, framing, transmit-overrun and receive-overrun flags. A flag never sets while its enable is 0.
- R8: The receive pending bit sets when the receive fill level becomes equal to receive-control bits 13:8. The transmit pending bit sets when the free count becomes equal to transmit-control bits 13:8. Writing 1 to bit 0 or bit 1 of 0x1C clears the transmit or receive pending bit. irq_tx and irq_rx show the pending bits gated by interrupt-enable bit 0 and bit 1.
- R9: While interrupt-enable bit 3 is set, irq_tx is also high whenever the transmit FIFO is empty.
- R10: irq_err is interrupt-enable bit 2 ANDed with the OR of the four sticky flags. It stays high until every set flag has been cleared.
- R11: In each FIFO control register, bit 0 enables the FIFO and writing 1 to bit 1 empties it. Bit 1 always reads 0. A disabled FIFO accepts no new entries.
- R12: tx_avail is high while the transmit FIFO is not empty, and tx_byte shows the oldest entry. A tx_pop pulse removes that entry.
- R13: After reset the receiver is in RXS_OFF, both FIFOs are disabled and empty, all enables and flags are 0, and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| rx_valid | input | 1 | Received character strobe |
| rx_byte | input | 8 | Received character |
| rx_par_err | input | 1 | Parity error on this character |
| rx_frm_err | input | 1 | Framing error on this character |
| tx_pop | input | 1 | Shifter takes the head of the transmit FIFO |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_avail | output | 1 | Transmit FIFO not empty |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The receive path is driven with clean characters, characters with a parity strobe and characters with a framing strobe. These show whether each strobe reaches only its own flag and whether flagged data is still stored. The FIFOs are filled to exactly 16 entries and then pushed once more, which separates a correct drop-and-keep on overrun from overwriting or wrapping. The same push pattern is repeated with the overrun enable off, with the receiver in RXS_OFF and with the FIFO disabled, to show that each gate stops the event. Zero-valued command writes, empty-FIFO reads and interrupt-clear writes confirm that the no-effect and clear paths change only what they should.

// File: rtl/urc_pkg.sv
package urc_pkg;
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_TXFC   = 8'h04;
    localparam logic [7:0] OFS_RXFC   = 8'h08;
    localparam logic [7:0] OFS_FSTAT  = 8'h0C;
    localparam logic [7:0] OFS_RXSTAT = 8'h10;
    localparam logic [7:0] OFS_CMD    = 8'h14;
    localparam logic [7:0] OFS_IEN    = 8'h18;
    localparam logic [7:0] OFS_ICLR   = 8'h1C;
    localparam logic [7:0] OFS_TXDATA = 8'h20;
    localparam logic [7:0] OFS_RXDATA = 8'h24;

    typedef enum logic {RXS_OFF, RXS_ON} rx_state_e;

    // bit order matches receiver status bits 16..19
    typedef struct packed {
        logic roe;
        logic toe;
        logic fe;
        logic pe;
    } err_flags_t;
endpackage

// File: rtl/urc_fifo.sv
module urc_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = en && push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign cnt_nxt = flush ? '0 : cnt + CW'(do_push) - CW'(do_pop);
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            cnt <= cnt_nxt;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= wr_ptr + 1'b1;
                if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/urc_rxctl.sv
module urc_rxctl
    import urc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [5:0] cmd,
    input  logic       rx_valid,
    input  logic       rx_par_err,
    input  logic       rx_frm_err,
    input  logic       rx_full,
    input  logic       tx_ovr,
    input  logic [3:0] err_en,
    output logic       rx_on,
    output err_flags_t flags
);
    rx_state_e  state_q, state_d;
    err_flags_t flags_q;
    logic       arrive;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXS_OFF: if (cmd_wr && cmd[1] && !cmd[0]) state_d = RXS_ON;
            RXS_ON:  if (cmd_wr && cmd[0])            state_d = RXS_OFF;
        endcase
    end

    always_comb begin
        rx_on = (state_q == RXS_ON);
        flags = flags_q;
    end

    assign arrive = rx_valid && rx_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q.pe  <= (arrive && rx_par_err && err_en[0]) || (flags_q.pe  && !(cmd_wr && cmd[2]));
            flags_q.fe  <= (arrive && rx_frm_err && err_en[1]) || (flags_q.fe  && !(cmd_wr && cmd[3]));
            flags_q.toe <= (tx_ovr && err_en[2])               || (flags_q.toe && !(cmd_wr && cmd[4]));
            flags_q.roe <= (arrive && rx_full && err_en[3])    || (flags_q.roe && !(cmd_wr && cmd[5]));
        end
    end
endmodule

// File: rtl/uart_regcore.sv
module uart_regcore
    import urc_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_par_err,
    input  logic        rx_frm_err,
    input  logic        tx_pop,
    output logic [7:0]  tx_byte,
    output logic        tx_avail,
    output logic        irq_tx,
    output logic        irq_rx,
    output logic        irq_err
);
    logic [3:0]    err_en;
    logic          txf_en, rxf_en;
    logic [5:0]    txf_lvl, rxf_lvl;
    logic [3:0]    ien;
    logic          tx_pend, rx_pend;
    logic          txf_flush, rxf_flush;
    logic          tx_push, rx_pop, tx_ovr, cmd_wr, rx_on;
    logic [CW-1:0] tx_cnt, tx_cnt_nxt, rx_cnt, rx_cnt_nxt;
    logic [CW-1:0] tx_free, tx_free_nxt;
    logic          tx_full, tx_empty, rx_full, rx_empty_unused;
    logic [7:0]    rx_head;
    err_flags_t    flags;
    logic          unused_wbits;

    assign unused_wbits = ^{wdata[31:20], wdata[15:14]};

    assign txf_flush = wr_en && (addr == OFS_TXFC) && wdata[1];
    assign rxf_flush = wr_en && (addr == OFS_RXFC) && wdata[1];
    assign tx_push   = wr_en && (addr == OFS_TXDATA);
    assign tx_ovr    = tx_push && tx_full && txf_en;
    assign rx_pop    = rd_en && (addr == OFS_RXDATA);
    assign cmd_wr    = wr_en && (addr == OFS_CMD);

    urc_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
        .clk(clk), .rst_n(rst_n), .en(txf_en), .flush(txf_flush),
        .push(tx_push), .din(wdata[7:0]), .pop(tx_pop), .dout(tx_byte),
        .cnt(tx_cnt), .cnt_nxt(tx_cnt_nxt), .full(tx_full), .empty(tx_empty)
    );

    urc_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
        .clk(clk), .rst_n(rst_n), .en(rxf_en), .flush(rxf_flush),
        .push(rx_valid && rx_on), .din(rx_byte), .pop(rx_pop), .dout(rx_head),
        .cnt(rx_cnt), .cnt_nxt(rx_cnt_nxt), .full(rx_full), .empty(rx_empty_unused)
    );

    urc_rxctl u_rxctl (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd(wdata[5:0]),
        .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
        .rx_full(rx_full), .tx_ovr(tx_ovr), .err_en(err_en),
        .rx_on(rx_on), .flags(flags)
    );

    assign tx_free     = CW'(DEPTH) - tx_cnt;
    assign tx_free_nxt = CW'(DEPTH) - tx_cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_en  <= '0;
            txf_en  <= 1'b0;
            rxf_en  <= 1'b0;
            txf_lvl <= '0;
            rxf_lvl <= '0;
            ien     <= '0;
            tx_pend <= 1'b0;
            rx_pend <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    OFS_CTRL: err_en <= wdata[19:16];
                    OFS_TXFC: begin txf_en <= wdata[0]; txf_lvl <= wdata[13:8]; end
                    OFS_RXFC: begin rxf_en <= wdata[0]; rxf_lvl <= wdata[13:8]; end
                    OFS_IEN:  ien <= wdata[3:0];
                    default: ;
                endcase
            end
            tx_pend <= ((6'(tx_free_nxt) == txf_lvl) && (6'(tx_free) != txf_lvl))
                    || (tx_pend && !(wr_en && (addr == OFS_ICLR) && wdata[0]));
            rx_pend <= ((6'(rx_cnt_nxt) == rxf_lvl) && (6'(rx_cnt) != rxf_lvl))
                    || (rx_pend && !(wr_en && (addr == OFS_ICLR) && wdata[1]));
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL:   rdata = {12'b0, err_en, 16'b0};
            OFS_TXFC:   rdata = {18'b0, txf_lvl, 7'b0, txf_en};
            OFS_RXFC:   rdata = {18'b0, rxf_lvl, 7'b0, rxf_en};
            OFS_FSTAT:  rdata = {2'b0, 6'(tx_free), 10'b0, 6'(tx_cnt), 2'b0, 6'(rx_cnt)};
            OFS_RXSTAT: rdata = {12'b0, flags, 15'b0, rx_on};
            OFS_IEN:    rdata = {28'b0, ien};
            OFS_RXDATA: rdata = {24'b0, rx_head};
            default:    rdata = '0;
        endcase
    end

    assign tx_avail = !tx_empty;
    assign irq_tx   = (tx_pend && ien[0]) || (tx_empty && ien[3]);
    assign irq_rx   = rx_pend && ien[1];
    assign irq_err  = ien[2] && (|flags);
endmodule

// File: rtl/urc_checker.sv
module urc_checker
    import urc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    addr,
    input logic          rx_valid,
    input logic          rx_on,
    input logic [CW-1:0] rx_cnt,
    input logic [3:0]    flags,
    input logic          irq_err
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    assert_full_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CW'(DEPTH) && !(rd_en && addr == OFS_RXDATA) && !wr_en) |=> rx_cnt == CW'(DEPTH));

    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_RXDATA && rx_cnt == '0 && !rx_valid) |=> rx_cnt == '0);

    assert_rx_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_on && !wr_en) |=> rx_cnt <= $past(rx_cnt));

    assert_sticky_pe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !wr_en) |=> flags[0]);

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_err) |-> $past(wr_en && (addr == OFS_CMD || addr == OFS_IEN)));
endmodule

bind uart_regcore urc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .rx_valid(rx_valid), .rx_on(rx_on), .rx_cnt(rx_cnt), .flags(flags),
    .irq_err(irq_err)
);

// File: tb/uart_regcore_tb.sv
`timescale 1ns/1ps
module uart_regcore_tb;
    localparam logic [7:0] A_CTRL = 8'h00, A_TXFC = 8'h04, A_RXFC = 8'h08, A_FST = 8'h0C;
    localparam logic [7:0] A_RST  = 8'h10, A_CMD  = 8'h14, A_IEN  = 8'h18, A_ICLR = 8'h1C;
    localparam logic [7:0] A_TXD  = 8'h20, A_RXD  = 8'h24;
    localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RX = 3'd2, OP_IRQ = 3'd3;

    // {req, op, addr, data, expected}
    localparam int NV = 31;
    localparam logic [78:0] VEC [NV] = '{
        {4'd1,  OP_RD,  A_FST,  32'h0,          32'h1000_0000}, // R1 empty status
        {4'd11, OP_WR,  A_RXFC, 32'h0000_0201,  32'h0},         // R11 enable, level 2
        {4'd11, OP_WR,  A_TXFC, 32'h0000_0E01,  32'h0},         // R11 enable, level 14
        {4'd7,  OP_WR,  A_CTRL, 32'h000F_0000,  32'h0},         // R7 all flag enables
        {4'd5,  OP_WR,  A_CMD,  32'h2,          32'h0},         // R5 receiver on
        {4'd5,  OP_RD,  A_RST,  32'h0,          32'h1},
        {4'd2,  OP_RX,  8'h0,   32'h041,        32'h0},         // R2 clean char
        {4'd1,  OP_RD,  A_FST,  32'h0,          32'h1000_0001},
        {4'd4,  OP_RX,  8'h0,   32'h142,        32'h0},         // R4 parity strobe
        {4'd4,  OP_RD,  A_RST,  32'h0,          32'h0001_0001},
        {4'd8,  OP_WR,  A_IEN,  32'h7,          32'h0},
        {4'd8,  OP_IRQ, 8'h0,   32'h0,          32'h6},         // R8 rx level hit
        {4'd1,  OP_WR,  A_TXD,  32'h55,         32'h0},
        {4'd1,  OP_WR,  A_TXD,  32'h66,         32'h0},
        {4'd8,  OP_IRQ, 8'h0,   32'h0,          32'h7},         // R8 tx free hit 14
        {4'd1,  OP_RD,  A_FST,  32'h0,          32'h0E00_0202},
        {4'd8,  OP_WR,  A_ICLR, 32'h3,          32'h0},
        {4'd8,  OP_IRQ, 8'h0,   32'h0,          32'h4},
        {4'd10, OP_WR,  A_CMD,  32'h4,          32'h0},
        {4'd10, OP_IRQ, 8'h0,   32'h0,          32'h0},         // R10 error line drops
        {4'd4,  OP_RD,  A_RST,  32'h0,          32'h1},
        {4'd2,  OP_RD,  A_RXD,  32'h0,          32'h41},
        {4'd2,  OP_RD,  A_RXD,  32'h0,          32'h42},
        {4'd2,  OP_RD,  A_RXD,  32'h0,          32'h0},         // R2 empty read
        {4'd2,  OP_RD,  A_FST,  32'h0,          32'h0E00_0200},
        {4'd4,  OP_RX,  8'h0,   32'h243,        32'h0},         // R4 framing strobe
        {4'd4,  OP_RD,  A_RST,  32'h0,          32'h0002_0001},
        {4'd10, OP_IRQ, 8'h0,   32'h0,          32'h4},
        {4'd5,  OP_WR,  A_CMD,  32'h8,          32'h0},
        {4'd10, OP_IRQ, 8'h0,   32'h0,          32'h0},
        {4'd2,  OP_RD,  A_RXD,  32'h0,          32'h43}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        rx_valid = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0, tx_pop = 1'b0;
    logic [7:0]  rx_byte = '0, tx_byte;
    logic        tx_avail, irq_tx, irq_rx, irq_err;
    int          total = 0, bad = 0;
    logic [31:0] rv;

    always #4 clk = ~clk;

    uart_regcore u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .tx_pop(tx_pop),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_err(irq_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b, input logic p, input logic f);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_par_err = p; rx_frm_err = f;
        @(negedge clk); rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    task automatic pop_tx();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 irq lines", {29'b0, irq_err, irq_rx, irq_tx}, 32'h0);
        chk("R13 tx_avail", {31'b0, tx_avail}, 32'h0);
        rd(A_RST, rv);  chk("R13 rx status", rv, 32'h0);
        rd(A_CTRL, rv); chk("R13 ctrl", rv, 32'h0);
        rd(A_IEN, rv);  chk("R13 irq enable", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  req;
            logic [2:0]  op;
            logic [7:0]  a;
            logic [31:0] d, e;
            {req, op, a, d, e} = VEC[i];
            unique case (op)
                OP_WR: wr(a, d);
                OP_RD: begin rd(a, rv); chk($sformatf("R%0d vec%0d", req, i), rv, e); end
                OP_RX: rx(d[7:0], d[8], d[9]);
                default: begin
                    @(negedge clk);
                    chk($sformatf("R%0d vec%0d", req, i), {29'b0, irq_err, irq_rx, irq_tx}, e);
                end
            endcase
        end

        // R12 transmit drain port
        chk("R12 avail", {31'b0, tx_avail}, 32'h1);
        chk("R12 head", {24'b0, tx_byte}, 32'h55);
        pop_tx();
        chk("R12 second", {24'b0, tx_byte}, 32'h66);
        pop_tx();
        chk("R12 drained", {31'b0, tx_avail}, 32'h0);

        // R9 empty-buffer interrupt
        wr(A_IEN, 32'h8);
        chk("R9 empty irq", {31'b0, irq_tx}, 32'h1);
        wr(A_TXD, 32'h11);
        chk("R9 nonempty irq", {31'b0, irq_tx}, 32'h0);
        pop_tx();
        wr(A_IEN, 32'h7);

        // R3 receive overrun: fill, one more, drop and keep
        for (int i = 0; i < 16; i++) rx(8'h80 + 8'(i), 1'b0, 1'b0);
        rd(A_FST, rv); chk("R3 full level", rv, 32'h1000_0010);
        rx(8'hEE, 1'b0, 1'b0);
        rd(A_RST, rv); chk("R3 overrun flag", rv, 32'h0008_0001);
        rd(A_FST, rv); chk("R3 level kept", rv, 32'h1000_0010);
        chk("R10 err line on overrun", {31'b0, irq_err}, 32'h1);
        for (int i = 0; i < 16; i++) begin
            rd(A_RXD, rv);
            chk($sformatf("R3 kept data %0d", i), rv, 32'h80 + i);
        end
        wr(A_CMD, 32'h20);
        rd(A_RST, rv); chk("R5 overrun cleared", rv, 32'h1);

        // R7 overrun enable off
        wr(A_CTRL, 32'h0007_0000);
        for (int i = 0; i < 17; i++) rx(8'(i), 1'b0, 1'b0);
        rd(A_RST, rv); chk("R7 gated overrun", rv, 32'h1);

        // R11 flush self-clearing
        wr(A_RXFC, 32'h0000_0203);
        rd(A_FST, rv);  chk("R11 flushed", rv, 32'h1000_0000);
        rd(A_RXFC, rv); chk("R11 flush reads 0", rv, 32'h0000_0201);

        // R5 zero command bits do nothing
        rx(8'h31, 1'b1, 1'b0);
        wr(A_CMD, 32'h0);
        rd(A_RST, rv); chk("R5 zero write", rv, 32'h0001_0001);
        wr(A_CMD, 32'h4);
        rd(A_RXD, rv); chk("R2 flagged byte stored", rv, 32'h31);

        // R5 receiver off drops characters; clear wins over set
        wr(A_CMD, 32'h3);
        rd(A_RST, rv); chk("R5 rx off", rv, 32'h0);
        rx(8'h77, 1'b1, 1'b0);
        rd(A_FST, rv); chk("R5 dropped while off", rv, 32'h1000_0000);
        rd(A_RST, rv); chk("R5 no flag while off", rv, 32'h0);
        wr(A_CMD, 32'h2);

        // R6 transmit overrun
        for (int i = 0; i < 17; i++) wr(A_TXD, 32'h20 + i);
        rd(A_RST, rv); chk("R6 tx overrun", rv, 32'h0004_0001);
        rd(A_FST, rv); chk("R1 tx full", rv, 32'h0000_1000);
        for (int i = 0; i < 16; i++) begin
            chk($sformatf("R6 tx data %0d", i), {24'b0, tx_byte}, 32'h20 + i);
            pop_tx();
        end
        wr(A_CMD, 32'h10);
        rd(A_RST, rv); chk("R5 tx overrun cleared", rv, 32'h1);

        // R11 disabled FIFO accepts nothing
        wr(A_RXFC, 32'h0000_0200);
        rx(8'h5A, 1'b0, 1'b0);
        rd(A_FST, rv); chk("R11 disabled fifo", rv, 32'h1000_0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule